// File: doc/BRIEF.md
# Exposure Shutter Timer

This block runs one camera exposure at a time from a free-running system clock. On a start command it takes the exposure kind, the role (timing master or follower), an integration length and two shutter settle lengths from its configuration inputs. It then steps through an open-settle phase, an integration phase and a close-settle phase. It drives a shutter command level while the shutter is meant to be open, and it ends with a one-clock readout strobe to the detector sequencer. Busy, done, abort and error status are reported on plain outputs.

All lengths are counted in ticks. A prescaler divides the clock by `TICK_DIV` to make one tick. With the default 40 MHz clock and a divisor of 40000, one tick is 1 ms. A phase programmed to L ticks lasts exactly L·TICK_DIV + 1 clock cycles, and each phase restarts the prescaler. Only the master times its own integration. When integration begins and when it ends, the master puts out a one-clock sync pulse on the shared line. A follower first finishes its own open settle. It then starts integrating on the next sync edge it receives and stops on the sync edge after that. Sync edges pass through two retiming flops before they are used.

Top module: `exposure_timer_ctl`

## Requirements
- R1: After reset, busy, shutter_open, readout_go, sync_out, done, err_sticky and aborted are all 0.
- R2: Object exposure (cfg_kind 2'b00), master: shutter_open rises in the first cycle after the accepted start. It stays high for an open phase of open·TICK_DIV+1 cycles and then an integration phase of int·TICK_DIV+1 cycles. It falls when the close phase begins.
- R3: Dark exposure (cfg_kind 2'b01) has the same phase timing as an object exposure, but shutter_open never rises.
- R4: Bias exposure (cfg_kind 2'b10 or 2'b11) goes straight to readout. readout_go is high for exactly the one cycle after the accepted start, with the shutter closed and no sync pulse.
- R5: After a close phase of close·TICK_DIV+1 cycles, readout_go is high for a single cycle. In the cycle after that, busy is 0 and done is 1.
- R6: A master drives sync_out high for one cycle in the first cycle of integration and for one cycle in the first cycle of the close phase. A follower never drives sync_out.
- R7: A follower ignores sync edges that arrive during its open phase. Once the open phase is over, a sync_in rise sampled at clock edge N starts integration at edge N+2. The next rise, sampled at edge M, starts the close phase at edge M+2, and shutter_open falls then.
- R8: A start while busy does not change the exposure in progress and sets err_sticky. clear_err clears err_sticky. When a busy start and clear_err arrive in the same cycle, the flag is set.
- R9: An abort_req while busy makes the next cycle show busy 0, shutter_open 0, done 1 and aborted 1, with no readout_go. An abort_req while idle changes nothing.
- R10: An accepted start clears done and aborted. The configuration is captured at the accepted start, and later changes do not affect the exposure in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: time the integration locally; 0: follow the sync line |
| cfg_kind | input | 2 | 00 object, 01 dark, 1x bias |
| cfg_int_ticks | input | INT_W | Integration length in ticks |
| cfg_open_ticks | input | SET_W | Open settle length in ticks |
| cfg_close_ticks | input | SET_W | Close settle length in ticks |
| start_cmd | input | 1 | Start request, one clock |
| clear_err | input | 1 | Clears the sticky error flag |
| abort_req | input | 1 | Abort the running exposure |
| sync_in | input | 1 | Shared sync line (follower input) |
| sync_out | output | 1 | Sync pulse driven by a master |
| shutter_open | output | 1 | Shutter open command |
| readout_go | output | 1 | One-clock readout start strobe |
| busy | output | 1 | Exposure in progress |
| done | output | 1 | Last exposure finished or aborted |
| err_sticky | output | 1 | A start arrived while busy |
| aborted | output | 1 | Last exposure was aborted |

## Verification
The hardest case to reach from the ports is a follower that receives a sync edge while its open settle is still running. That edge must be dropped, and the next one must still be honoured two flops later. The bench runs a follower exposure and pulses sync_in a few cycles into the open phase. It then pulses again after the phase has expired and once more later to end integration. A behavioural model with its own three-deep sample history of the line predicts the cycle in which the shutter closes. Aborts and busy starts are placed in the middle of integration, and one busy start lands in the same cycle as clear_err, so that the set-over-clear rule shows up at the ports.

// File: rtl/exp_timer_pkg.sv
package exp_timer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPEN  = 3'd1,
    PH_WSYNC = 3'd2,
    PH_INTEG = 3'd3,
    PH_CLOSE = 3'd4,
    PH_READ  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    EXP_OBJECT   = 2'b00,
    EXP_DARK     = 2'b01,
    EXP_BIAS     = 2'b10,
    EXP_BIAS_ALT = 2'b11
  } exp_kind_e;

  // Bias kinds (upper bit set) skip shutter and integration entirely.
  function automatic logic kind_skips_integ(input logic [1:0] kind);
    return kind[1];
  endfunction

  // Only an object exposure moves the shutter.
  function automatic logic kind_opens_shutter(input logic [1:0] kind);
    return kind == EXP_OBJECT;
  endfunction

  // Phases during which the shutter command is held for an object exposure.
  function automatic logic phase_shutter_window(input phase_e ph);
    return (ph == PH_OPEN) || (ph == PH_WSYNC) || (ph == PH_INTEG);
  endfunction

endpackage

// File: rtl/exp_sync_rx.sv
module exp_sync_rx #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic sync_evt
);
  // STAGES retiming flops plus one more for edge detection.
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], sync_in};
  end

  assign sync_evt = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/exp_tick_timer.sv
module exp_tick_timer #(
  parameter int DIV   = 40000,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] left_q;
  logic             tick_w;

  assign expired = (left_q == '0);
  assign tick_w  = !expired && (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      pre_q  <= '0;
      left_q <= load_val;
    end else if (!expired) begin
      if (tick_w) begin
        pre_q  <= '0;
        left_q <= left_q - 1'b1;
      end else begin
        pre_q  <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/exp_status_flags.sv
module exp_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  input  logic start_busy,
  input  logic clear_err,
  input  logic finish,
  input  logic abort_hit,
  output logic done,
  output logic aborted,
  output logic err_sticky
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      aborted    <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      if (start_ok)                    done <= 1'b0;
      else if (finish || abort_hit)    done <= 1'b1;

      if (start_ok)       aborted <= 1'b0;
      else if (abort_hit) aborted <= 1'b1;

      if (start_busy)     err_sticky <= 1'b1;
      else if (clear_err) err_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/exposure_timer_ctl.sv
module exposure_timer_ctl
  import exp_timer_pkg::*;
#(
  parameter int TICK_DIV    = 40000,
  parameter int INT_W       = 32,
  parameter int SET_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic [1:0]       cfg_kind,
  input  logic [INT_W-1:0] cfg_int_ticks,
  input  logic [SET_W-1:0] cfg_open_ticks,
  input  logic [SET_W-1:0] cfg_close_ticks,
  input  logic             start_cmd,
  input  logic             clear_err,
  input  logic             abort_req,
  input  logic             sync_in,
  output logic             sync_out,
  output logic             shutter_open,
  output logic             readout_go,
  output logic             busy,
  output logic             done,
  output logic             err_sticky,
  output logic             aborted
);
  phase_e           state_q, state_n;
  logic [1:0]       kind_q;
  logic             master_q;
  logic [INT_W-1:0] int_q;
  logic [SET_W-1:0] close_q;
  logic             sync_q;

  // Named events, visible to the checker.
  logic             start_ok, start_busy, abort_hit, finish;
  logic             sync_evt, tmr_expired, tmr_load;
  logic [INT_W-1:0] tmr_val;

  assign start_ok   = start_cmd && (state_q == PH_IDLE);
  assign start_busy = start_cmd && (state_q != PH_IDLE);
  assign abort_hit  = abort_req && (state_q != PH_IDLE);
  assign finish     = (state_q == PH_READ) && !abort_hit;

  exp_sync_rx #(.STAGES(SYNC_STAGES)) sync_rx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_in),
    .sync_evt (sync_evt)
  );

  // Next phase.
  always_comb begin
    state_n = state_q;
    if (abort_hit) begin
      state_n = PH_IDLE;
    end else begin
      unique case (state_q)
        PH_IDLE:
          if (start_ok)
            state_n = kind_skips_integ(cfg_kind) ? PH_READ : PH_OPEN;
        PH_OPEN:
          if (tmr_expired) state_n = master_q ? PH_INTEG : PH_WSYNC;
        PH_WSYNC:
          if (sync_evt) state_n = PH_INTEG;
        PH_INTEG:
          if (master_q ? tmr_expired : sync_evt) state_n = PH_CLOSE;
        PH_CLOSE:
          if (tmr_expired) state_n = PH_READ;
        PH_READ:
          state_n = PH_IDLE;
        default:
          state_n = PH_IDLE;
      endcase
    end
  end

  // The timer restarts with the length of whichever timed phase is entered.
  assign tmr_load = (state_n != state_q);
  always_comb begin
    unique case (state_n)
      PH_OPEN:  tmr_val = INT_W'(cfg_open_ticks);
      PH_INTEG: tmr_val = int_q;
      PH_CLOSE: tmr_val = INT_W'(close_q);
      default:  tmr_val = '0;
    endcase
  end

  exp_tick_timer #(.DIV(TICK_DIV), .CNT_W(INT_W)) tick_timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_IDLE;
      kind_q   <= EXP_OBJECT;
      master_q <= 1'b0;
      int_q    <= '0;
      close_q  <= '0;
      sync_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      if (start_ok) begin
        kind_q   <= cfg_kind;
        master_q <= cfg_master;
        int_q    <= cfg_int_ticks;
        close_q  <= cfg_close_ticks;
      end
      sync_q <= master_q && !abort_hit &&
                (((state_q == PH_OPEN)  && (state_n == PH_INTEG)) ||
                 ((state_q == PH_INTEG) && (state_n == PH_CLOSE)));
    end
  end

  exp_status_flags flags_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ok   (start_ok),
    .start_busy (start_busy),
    .clear_err  (clear_err),
    .finish     (finish),
    .abort_hit  (abort_hit),
    .done       (done),
    .aborted    (aborted),
    .err_sticky (err_sticky)
  );

  assign busy         = (state_q != PH_IDLE);
  assign readout_go   = (state_q == PH_READ);
  assign shutter_open = kind_opens_shutter(kind_q) && phase_shutter_window(state_q);
  assign sync_out     = sync_q;
endmodule

// File: rtl/exposure_timer_ctl_chk.sv
module exposure_timer_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_cmd,
  input logic       abort_req,
  input logic       busy,
  input logic       done,
  input logic       aborted,
  input logic       err_sticky,
  input logic       shutter_open,
  input logic       readout_go,
  input logic       sync_out,
  input logic [1:0] kind_q,
  input logic       master_q
);
  // R2
  shutter_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutter_open |-> busy);

  // R3
  dark_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == 2'b01) |-> !shutter_open);

  // R5
  readout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_go && !abort_req) |=> (!readout_go && !busy && done));

  // R6
  follower_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out && busy) |-> master_q);

  // R8
  busy_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_cmd) |=> err_sticky);

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort_req) |=> (!busy && done && aborted && !shutter_open && !readout_go));

  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_cmd) |=> (busy && !done && !aborted));
endmodule

bind exposure_timer_ctl exposure_timer_ctl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_cmd    (start_cmd),
  .abort_req    (abort_req),
  .busy         (busy),
  .done         (done),
  .aborted      (aborted),
  .err_sticky   (err_sticky),
  .shutter_open (shutter_open),
  .readout_go   (readout_go),
  .sync_out     (sync_out),
  .kind_q       (kind_q),
  .master_q     (master_q)
);

// File: tb/exposure_timer_ctl_tb_top.sv
`timescale 1ns/1ps
module exposure_timer_ctl_tb_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_master = 1'b1;
  logic [1:0]  cfg_kind = 2'b00;
  logic [31:0] cfg_int_ticks = 32'd3;
  logic [15:0] cfg_open_ticks = 16'd2;
  logic [15:0] cfg_close_ticks = 16'd1;
  logic        start_cmd = 1'b0, clear_err = 1'b0, abort_req = 1'b0, sync_in = 1'b0;
  logic        sync_out, shutter_open, readout_go, busy, done, err_sticky, aborted;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;  // 250 MHz

  exposure_timer_ctl #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_kind(cfg_kind),
    .cfg_int_ticks(cfg_int_ticks), .cfg_open_ticks(cfg_open_ticks),
    .cfg_close_ticks(cfg_close_ticks), .start_cmd(start_cmd), .clear_err(clear_err),
    .abort_req(abort_req), .sync_in(sync_in), .sync_out(sync_out),
    .shutter_open(shutter_open), .readout_go(readout_go), .busy(busy), .done(done),
    .err_sticky(err_sticky), .aborted(aborted)
  );

  // Behavioural reference: phase number plus a remaining-cycle count.
  int m_ph, m_rem, m_int, m_close;
  bit m_master, m_obj, m_done, m_err, m_abt, m_sync;
  bit s1, s2, s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_rem = 0; m_done = 0; m_err = 0; m_abt = 0; m_sync = 0;
      m_master = 0; m_obj = 0; m_int = 0; m_close = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      bit ev;
      bit was_busy;
      ev = s2 && !s3;
      s3 = s2; s2 = s1; s1 = sync_in;
      was_busy = (m_ph != 0);
      m_sync = 0;
      if (was_busy && start_cmd) m_err = 1;
      else if (clear_err)        m_err = 0;
      if (was_busy && abort_req) begin
        m_ph = 0; m_done = 1; m_abt = 1;
      end else begin
        case (m_ph)
          0: if (start_cmd) begin
               m_master = cfg_master; m_obj = (cfg_kind == 2'b00);
               m_int = cfg_int_ticks; m_close = cfg_close_ticks;
               m_done = 0; m_abt = 0;
               if (cfg_kind >= 2'b10) m_ph = 5;
               else begin m_ph = 1; m_rem = cfg_open_ticks * DIV; end
             end
          1: if (m_rem == 0) begin
               if (m_master) begin m_ph = 3; m_rem = m_int * DIV; m_sync = 1; end
               else m_ph = 2;
             end else m_rem--;
          2: if (ev) m_ph = 3;
          3: if (m_master) begin
               if (m_rem == 0) begin m_ph = 4; m_rem = m_close * DIV; m_sync = 1; end
               else m_rem--;
             end else if (ev) begin m_ph = 4; m_rem = m_close * DIV; end
          4: if (m_rem == 0) m_ph = 5; else m_rem--;
          default: begin m_ph = 0; m_done = 1; end
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_sh;
      e_sh = m_obj && (m_ph >= 1 && m_ph <= 3);
      chk(shutter_open == e_sh, "R2 R3 R7 shutter_open", shutter_open, e_sh);
      chk(readout_go == (m_ph == 5), "R4 R5 readout_go", readout_go, m_ph == 5);
      chk(busy == (m_ph != 0), "R5 R9 busy", busy, m_ph != 0);
      chk(done == m_done, "R5 R9 R10 done", done, m_done);
      chk(err_sticky == m_err, "R8 err_sticky", err_sticky, m_err);
      chk(aborted == m_abt, "R9 R10 aborted", aborted, m_abt);
      chk(sync_out == m_sync, "R6 sync_out", sync_out, m_sync);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic start(input bit m, input logic [1:0] k, input int o, input int i, input int c);
    @(negedge clk);
    cfg_master = m; cfg_kind = k; cfg_open_ticks = 16'(o);
    cfg_int_ticks = i; cfg_close_ticks = 16'(c);
    start_cmd = 1;
    @(negedge clk);
    start_cmd = 0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 3000 && busy; n++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_in = 1;
    @(negedge clk); sync_in = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !shutter_open && !readout_go && !sync_out, "R1 outputs idle", busy, 0);
    chk(!done && !err_sticky && !aborted, "R1 flags clear", done, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 object master, R6 sync pulses
    start(1, 2'b00, 2, 3, 1);
    wait_idle();
    chk(done == 1, "R5 done after object", done, 1);
    // R3 dark
    start(1, 2'b01, 1, 2, 2);
    wait_idle();
    // R4 bias, both encodings
    start(1, 2'b10, 5, 5, 5);
    wait_idle();
    start(0, 2'b11, 5, 5, 5);
    wait_idle();

    // R8 busy start ignored, R10 config change mid-run ignored
    start(1, 2'b00, 1, 4, 1);
    repeat (10) @(negedge clk);
    cfg_kind = 2'b01; cfg_int_ticks = 40; start_cmd = 1;
    @(negedge clk); start_cmd = 0;
    chk(err_sticky == 1, "R8 err set", err_sticky, 1);
    clear_err = 1; @(negedge clk); clear_err = 0;
    chk(err_sticky == 0, "R8 err cleared", err_sticky, 0);
    start_cmd = 1; clear_err = 1;
    @(negedge clk); start_cmd = 0; clear_err = 0;
    chk(err_sticky == 1, "R8 set wins over clear", err_sticky, 1);
    wait_idle();
    clear_err = 1; @(negedge clk); clear_err = 0;

    // R9 abort mid-integration, then abort while idle
    start(1, 2'b00, 1, 6, 1);
    repeat (9) @(negedge clk);
    abort_req = 1; @(negedge clk); abort_req = 0;
    chk(aborted == 1 && !busy, "R9 aborted", aborted, 1);
    repeat (3) @(negedge clk);
    abort_req = 1; @(negedge clk); abort_req = 0;
    chk(aborted == 1 && done == 1 && !busy, "R9 idle abort no effect", busy, 0);
    // R10 new start clears aborted
    start(1, 2'b00, 0, 0, 0);
    chk(aborted == 0 && done == 0, "R10 start clears flags", aborted, 0);
    wait_idle();

    // R7 follower: early sync ignored, then start and end edges
    start(0, 2'b00, 2, 99, 1);
    repeat (2) @(negedge clk);
    pulse_sync();
    repeat (12) @(negedge clk);
    chk(busy && shutter_open, "R7 waiting open", shutter_open, 1);
    pulse_sync();
    repeat (6) @(negedge clk);
    chk(busy && shutter_open, "R7 integrating", shutter_open, 1);
    pulse_sync();
    wait_idle();
    chk(done == 1, "R7 follower done", done, 1);

    // follower dark with abort in close phase
    start(0, 2'b01, 0, 0, 8);
    repeat (3) @(negedge clk);
    pulse_sync();
    repeat (3) @(negedge clk);
    pulse_sync();
    repeat (6) @(negedge clk);
    abort_req = 1; @(negedge clk); abort_req = 0;
    wait_idle();

    finish_run();
  end
endmodule